// File: doc/BRIEF.md
# GPIO Controller with Routed Interrupt Groups

This block controls a parameterised set of general-purpose pins through a 32-bit register bus. Each pin owns one configuration word that sets whether it drives an output, what interrupt condition it watches for, which of eight interrupt groups its events go to, and a lock that guards the word. Pull, drive-strength, Schmitt and function-select fields are kept and read back but have no effect on the logic.

Pin inputs pass through a two-stage synchronizer. Software reads the live synchronized level through the data bit of an input pin. A rising edge, a falling edge, either edge, or a held high or low level can each raise a pending bit. Pending bits sit in one bitmap per group. Software clears them by writing ones. Each group drives its own registered interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every implemented pin word reads 0x0000_000E (mode 7, all else zero), every pending word reads 0 and all interrupt lines are low.
- R2: A write to pin word n at byte address 4*n stores the bits in mask 0x00E7_8FEF: data bit 0, mode bits 3:1, function bits 6:5, pull bits 8:7, input enable bit 9, drive bits 11:10 and 23:22, Schmitt bit 15, group bits 18:16 and lock bit 21. All other bits read 0.
- R3: When the mode is 1, the pin's output enable is high and its output follows data bit 0. For every other mode the output enable is low.
- R4: When the mode is not 1, bit 0 of a read returns the pin level after two synchronizing flops, not the stored bit.
- R5: While lock bit 21 of a pin word is 1, a write with bit 21 set leaves the word unchanged. A write with bit 21 clear only clears the lock and changes no other bit.
- R6: Mode 2 (level high) and mode 3 (level low) set the pin's pending bit on every cycle the synchronized level matches, so a cleared bit comes back while the level holds.
- R7: Mode 4 sets pending on a rising edge, mode 5 on a falling edge and mode 6 on either edge. Modes 0, 1 and 7 never set pending.
- R8: The pending bit of pin p in group g (group = bits 18:16) is bit p%32 of the word at 0x800 + 0x40*g + 4*(p/32). Writing 1 there clears it and writing 0 leaves it. A set in the same cycle wins over a clear.
- R9: Interrupt line g is high one cycle after any pending bit in group g belongs to a pin whose group field currently equals g.
- R10: Pin words at or above the pin count, and pending words beyond the pin count, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid the next cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output data per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | NUM_GROUPS | One interrupt line per group |

## Verification
The detection logic is driven with steady high and low levels, single rising and falling transitions, and toggles under the inactive modes. This separates level re-arming from one-shot edge capture and shows that the inactive modes stay silent. One pin sits in the second pending word, so the word and bit address arithmetic is tested beyond word 0. Regrouping a pin that has a pending bit shows the interrupt following the current group field rather than where the bit was stored. Lock sequences with bit 21 set and then clear tell an ignored write apart from a write that only unlocks.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int          CFG_W     = 32;
  localparam logic [31:0] CFG_RESET = 32'h0000_000E;
  localparam logic [31:0] CFG_MASK  = 32'h00E7_8FEF;
  localparam int          B_DATA    = 0;
  localparam int          B_LOCK    = 21;
  localparam int          MODE_LSB  = 1;
  localparam int          GRP_LSB   = 16;
  localparam int          ADDR_W    = 12;

  typedef enum logic [2:0] {
    M_IN   = 3'd0,
    M_OUT  = 3'd1,
    M_HI   = 3'd2,
    M_LO   = 3'd3,
    M_RISE = 3'd4,
    M_FALL = 3'd5,
    M_BOTH = 3'd6,
    M_OFF  = 3'd7
  } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      lvl    <= '0;
      lvl_d  <= '0;
    end else begin
      stage1 <= raw;
      lvl    <= stage1;
      lvl_d  <= lvl;
    end
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int N = 8
) (
  input  logic [N-1:0][2:0] mode,
  input  logic [N-1:0]      lvl,
  input  logic [N-1:0]      lvl_d,
  output logic [N-1:0]      evt
);
  import gpio_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      unique case (pin_mode_e'(mode[i]))
        M_HI:    evt[i] = lvl[i];
        M_LO:    evt[i] = ~lvl[i];
        M_RISE:  evt[i] = lvl[i] & ~lvl_d[i];
        M_FALL:  evt[i] = ~lvl[i] & lvl_d[i];
        M_BOTH:  evt[i] = lvl[i] ^ lvl_d[i];
        default: evt[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pending.sv
module gpio_pending #(
  parameter int N = 8,
  parameter int G = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      evt,
  input  logic [N-1:0][2:0] grp,
  input  logic              clr_en,
  input  logic [2:0]        clr_grp,
  input  logic [3:0]        clr_word,
  input  logic [31:0]       clr_mask,
  output logic [G-1:0][N-1:0] pend,
  output logic [G-1:0]      irq
);
  logic [G-1:0] hit;

  for (genvar g = 0; g < G; g++) begin : g_grp
    logic [N-1:0] member;
    for (genvar p = 0; p < N; p++) begin : g_bit
      logic set_b, clr_b;
      assign member[p] = (grp[p] == 3'(g));
      assign set_b = evt[p] & member[p];
      assign clr_b = clr_en && (clr_grp == 3'(g)) &&
                     (clr_word == 4'(p / 32)) && clr_mask[p % 32];
      always_ff @(posedge clk) begin
        if (rst)        pend[g][p] <= 1'b0;
        else if (set_b) pend[g][p] <= 1'b1;
        else if (clr_b) pend[g][p] <= 1'b0;
      end
    end
    assign hit[g] = |(pend[g] & member);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= hit;
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [11:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_GROUPS-1:0] irq
);
  import gpio_pkg::*;

  localparam int WORDS = (NUM_PINS + 31) / 32;
  localparam int IW    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0][31:0]   cfg;
  logic [NUM_PINS-1:0][2:0]    mode_v;
  logic [NUM_PINS-1:0][2:0]    grp_v;
  logic [NUM_PINS-1:0]         lvl, lvl_d, evt;
  logic [NUM_GROUPS-1:0][NUM_PINS-1:0]  pend;
  logic [NUM_GROUPS-1:0][WORDS*32-1:0]  pend_pad;

  // address decode
  logic [8:0]    widx;
  logic [IW-1:0] pidx;
  logic [2:0]    pgrp;
  logic [3:0]    pword;
  logic          pin_sel, pend_sel;

  assign widx     = bus_addr[10:2];
  assign pidx     = widx[IW-1:0];
  assign pgrp     = bus_addr[8:6];
  assign pword    = bus_addr[5:2];
  assign pin_sel  = !bus_addr[11] && (int'(widx) < NUM_PINS);
  assign pend_sel = bus_addr[11] && (bus_addr[10:9] == 2'b00) &&
                    (int'(pgrp) < NUM_GROUPS) && (int'(pword) < WORDS);

  // per-pin configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) cfg[i] <= CFG_RESET;
    end else if (bus_wr && pin_sel) begin
      if (cfg[pidx][B_LOCK]) begin
        if (!bus_wdata[B_LOCK]) cfg[pidx][B_LOCK] <= 1'b0;
      end else begin
        cfg[pidx] <= bus_wdata & CFG_MASK;
      end
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fields
    assign mode_v[i]  = cfg[i][MODE_LSB +: 3];
    assign grp_v[i]   = cfg[i][GRP_LSB +: 3];
    assign pin_out[i] = cfg[i][B_DATA];
    assign pin_oe[i]  = (mode_v[i] == M_OUT);
  end

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw   (pin_in),
    .lvl   (lvl),
    .lvl_d (lvl_d)
  );

  gpio_detect #(.N(NUM_PINS)) u_detect (
    .mode  (mode_v),
    .lvl   (lvl),
    .lvl_d (lvl_d),
    .evt   (evt)
  );

  gpio_pending #(.N(NUM_PINS), .G(NUM_GROUPS)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .grp      (grp_v),
    .clr_en   (bus_wr && pend_sel),
    .clr_grp  (pgrp),
    .clr_word (pword),
    .clr_mask (bus_wdata),
    .pend     (pend),
    .irq      (irq)
  );

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      pend_pad[g] = '0;
      pend_pad[g][NUM_PINS-1:0] = pend[g];
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (pin_sel) begin
        bus_rdata <= cfg[pidx];
        if (mode_v[pidx] != M_OUT) bus_rdata[B_DATA] <= lvl[pidx];
      end else if (pend_sel) begin
        bus_rdata <= pend_pad[pgrp][{pword, 5'b0} +: 32];
      end else begin
        bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int N = 64,
  parameter int G = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [N-1:0]       pin_out,
  input logic [G-1:0]       irq,
  input logic [N-1:0][31:0] cfg,
  input logic [G-1:0][N-1:0] pend,
  input logic [N-1:0]       evt
);
  // R1: lines are low right after a reset cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0));

  // R3: output data only moves after a bus write
  p_out_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(pin_out));

  for (genvar p = 0; p < N; p++) begin : g_pin
    // R5: a locked word ignores writes that keep the lock bit set
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
      $past(bus_wr && (bus_addr == 12'(4 * p)) && cfg[p][21] && bus_wdata[21])
      |-> $stable(cfg[p]));

    for (genvar g = 0; g < G; g++) begin : g_grp
      // R7: a pending bit only rises after a detection event routed to its group
      p_rise_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[g][p]) |-> $past(evt[p] && (cfg[p][18:16] == 3'(g))));

      // R8: write-one clears the bit when no event competes
      p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && (bus_addr == 12'(12'h800 + 64 * g + 4 * (p / 32))) &&
              bus_wdata[p % 32] && !(evt[p] && (cfg[p][18:16] == 3'(g))))
        |-> !pend[g][p]);
    end
  end

  for (genvar g = 0; g < G; g++) begin : g_line
    // R9: a line is only high when its group held a pending bit one cycle earlier
    p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
      irq[g] |-> $past(|pend[g]));
  end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.N(NUM_PINS), .G(NUM_GROUPS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .irq       (irq),
  .cfg       (cfg),
  .pend      (pend),
  .evt       (evt)
);

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  localparam int NP = 64;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NG-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] pend_addr(input int g, input int p);
    return 12'(12'h800 + 64 * g + 4 * (p / 32));
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v);          chk("R1 pin0 word", v, 32'h0000_000E);
    rd(12'(4 * 63), v);      chk("R1 pin63 word", v, 32'h0000_000E);
    rd(pend_addr(3, 40), v); chk("R1 pending word", v, 32'h0);
    chk("R1 irq lines", 32'(irq), 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(12'(4 * 5), 32'hFFDF_FFFF);
    rd(12'(4 * 5), v);
    chk("R2 masked readback", v, 32'h00C7_8FEE);
    chk("R3 oe low in mode 7", 32'(pin_oe[5]), 32'h0);
    wr(12'(4 * 5), 32'h0000_000E);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(12'(4 * 3), 32'h0000_0003);
    chk("R3 oe high in mode 1", 32'(pin_oe[3]), 32'h1);
    chk("R3 out follows data 1", 32'(pin_out[3]), 32'h1);
    chk("R3 neighbour oe low", 32'(pin_oe[4]), 32'h0);
    rd(12'(4 * 3), v);
    chk("R3 output word readback", v, 32'h3);
    wr(12'(4 * 3), 32'h0000_0002);
    chk("R3 out follows data 0", 32'(pin_out[3]), 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    wr(12'(4 * 3), 32'h0000_000E);
    pin_in[3] = 1'b1;
    rd(12'(4 * 3), v);
    chk("R4 level not yet through sync", v, 32'h0000_000E);
    idle(3);
    rd(12'(4 * 3), v);
    chk("R4 live level read", v, 32'h0000_000F);
    pin_in[3] = 1'b0;
    idle(3);
    rd(12'(4 * 3), v);
    chk("R4 live level low", v, 32'h0000_000E);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(12'(4 * 7), 32'h0020_0003);
    wr(12'(4 * 7), 32'h0020_0000);
    rd(12'(4 * 7), v);
    chk("R5 locked write ignored", v, 32'h0020_0003);
    chk("R5 locked output held", 32'(pin_out[7]), 32'h1);
    wr(12'(4 * 7), 32'h0000_0000);
    rd(12'(4 * 7), v);
    chk("R5 unlock only clears lock", v, 32'h0000_0003);
    wr(12'(4 * 7), 32'h0000_0002);
    rd(12'(4 * 7), v);
    chk("R5 write after unlock", v, 32'h0000_0002);
    wr(12'(4 * 7), 32'h0000_000E);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(12'(4 * 10), 32'h0002_0004);     // group 2, level high
    idle(4);
    rd(pend_addr(2, 10), v); chk("R6 no pending while low", v, 32'h0);
    pin_in[10] = 1'b1;
    idle(5);
    rd(pend_addr(2, 10), v); chk("R8 level-high pending bit", v, 32'h400);
    chk("R9 group 2 line", 32'(irq), 32'h04);
    wr(pend_addr(2, 10), 32'h400);
    rd(pend_addr(2, 10), v); chk("R6 re-arms while held", v, 32'h400);
    pin_in[10] = 1'b0;
    idle(4);
    wr(pend_addr(2, 10), 32'h400);
    rd(pend_addr(2, 10), v); chk("R8 cleared after release", v, 32'h0);
    idle(2);
    chk("R9 group 2 line drops", 32'(irq), 32'h0);
    wr(12'(4 * 10), 32'h0002_0006);     // level low
    idle(4);
    rd(pend_addr(2, 10), v); chk("R6 level-low pending", v, 32'h400);
    wr(12'(4 * 10), 32'h0002_000E);
    wr(pend_addr(2, 10), 32'hFFFF_FFFF);
    rd(pend_addr(2, 10), v); chk("R8 clear all", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(12'(4 * 40), 32'h0005_0008);     // group 5, rising
    pin_in[40] = 1'b1;
    idle(5);
    rd(pend_addr(5, 40), v); chk("R7 rising sets word1 bit 8", v, 32'h100);
    chk("R9 group 5 line", 32'(irq), 32'h20);
    wr(pend_addr(5, 40), 32'h0);
    rd(pend_addr(5, 40), v); chk("R8 zero write keeps bit", v, 32'h100);
    wr(12'(4 * 40), 32'h0001_000C);     // move to group 1
    idle(2);
    chk("R9 line follows current group", 32'(irq), 32'h0);
    wr(12'(4 * 40), 32'h0005_0008);
    idle(2);
    chk("R9 line back with group 5", 32'(irq), 32'h20);
    wr(pend_addr(5, 40), 32'h100);
    idle(3);
    rd(pend_addr(5, 40), v); chk("R7 rising is one-shot", v, 32'h0);
    wr(12'(4 * 40), 32'h0005_000A);     // falling
    pin_in[40] = 1'b0;
    idle(5);
    rd(pend_addr(5, 40), v); chk("R7 falling sets", v, 32'h100);
    wr(pend_addr(5, 40), 32'h100);
    wr(12'(4 * 40), 32'h0005_000C);     // both
    pin_in[40] = 1'b1;
    idle(5);
    rd(pend_addr(5, 40), v); chk("R7 both on rise", v, 32'h100);
    wr(pend_addr(5, 40), 32'h100);
    pin_in[40] = 1'b0;
    idle(5);
    rd(pend_addr(5, 40), v); chk("R7 both on fall", v, 32'h100);
    wr(pend_addr(5, 40), 32'h100);
    wr(12'(4 * 40), 32'h0005_000E);     // off
    pin_in[40] = 1'b1; idle(4); pin_in[40] = 1'b0; idle(4);
    rd(pend_addr(5, 40), v); chk("R7 mode 7 silent", v, 32'h0);
    wr(12'(4 * 40), 32'h0005_0000);     // plain input
    pin_in[40] = 1'b1; idle(4); pin_in[40] = 1'b0; idle(4);
    rd(pend_addr(5, 40), v); chk("R7 mode 0 silent", v, 32'h0);
    chk("R9 all lines low", 32'(irq), 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(12'(4 * 100), 32'h0000_0003);
    rd(12'(4 * 100), v);  chk("R10 absent pin word", v, 32'h0);
    rd(12'h808, v);       chk("R10 absent pending word", v, 32'h0);
    chk("R10 no pin driven", 32'(|pin_oe), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_output();
    t_input();
    t_lock();
    t_level();
    t_edge();
    t_unimpl();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule